// File: doc/BRIEF.md
# Auto-Incrementing Colour Palette Port

This block holds a 256-entry colour lookup table whose entries are 18 bits wide: a 6-bit red, green and blue component each. Software loads the table through two byte-wide write strobes. A write to the index port picks the entry to start at. A run of writes to the data port then supplies components three at a time, in red, green, blue order. After each blue byte the entry pointer moves on by itself, so a whole range of entries can be loaded by setting the index once and streaming bytes.

On the display side, every pixel clock the block takes a pixel index, ANDs it with a software-loaded pixel mask and presents the selected entry as one 18-bit RGB word, registered once. Red and green are held in staging registers until the blue byte arrives. The whole entry is then written in a single cycle, so the display never sees an entry that is only partly updated.

Top module: `pal_dac_port`

## Requirements
- R1: While reset is high, and on the first cycle after it, `rgb_out` is 0. Reset leaves the entry pointer at 0, the component sequence at red and the pixel mask at 0xFF.
- R2: A write to the index port loads the entry pointer and restarts the component sequence at red. Any red or green bytes already staged are discarded.
- R3: Successive data-port writes supply red, then green, then blue of the entry the pointer selects. `rgb_out` packs an entry as red in bits [17:12], green in [11:6] and blue in [5:0].
- R4: The pointer increments by one after each blue write and wraps from 255 to 0.
- R5: Bits [7:6] of each data byte are ignored. Only bits [5:0] are stored, so the largest component value is 0x3F.
- R6: `rgb_out` shows, one clock after the edge that samples `pix_idx`, the entry at address `pix_idx & mask`.
- R7: A write to the mask port loads the 8-bit pixel mask used by the lookup.
- R8: When an index write and a data write happen in the same cycle, the index write takes effect and the data byte is ignored.
- R9: A table entry changes only on a blue write. An interrupted red/green sequence leaves the entry with its old contents.
- R10: Writing index N once and then streaming 192 data bytes loads 64 consecutive entries, N through N+63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel and register clock |
| rst | input | 1 | Synchronous active-high reset |
| idx_we | input | 1 | Index-port write strobe |
| idx_wdata | input | 8 | Starting entry number |
| data_we | input | 1 | Data-port write strobe |
| data_wdata | input | 8 | Component byte; bits [5:0] used |
| mask_we | input | 1 | Mask-port write strobe |
| mask_wdata | input | 8 | New pixel mask value |
| pix_idx | input | 8 | Pixel colour index |
| rgb_out | output | 18 | Registered colour {red, green, blue} |

## Verification
The assertions assume that every strobe is 0 or 1 at each rising edge and that a write's data is valid in the same cycle as its strobe. They also assume that `pix_idx` is known whenever the output is used. The stimulus changes all inputs on the falling clock edge and holds each strobe for exactly one full cycle, so every write is sampled once. Only table entries that have been written are ever looked up.

// File: rtl/pal_pkg.sv
package pal_pkg;
    localparam int COMP_W = 6;
    localparam int RGB_W  = 3 * COMP_W;

    typedef enum logic [1:0] {
        PH_RED   = 2'd0,
        PH_GREEN = 2'd1,
        PH_BLUE  = 2'd2
    } comp_phase_e;

    typedef struct packed {
        logic [COMP_W-1:0] r;
        logic [COMP_W-1:0] g;
        logic [COMP_W-1:0] b;
    } rgb_t;

    function automatic comp_phase_e next_phase(input comp_phase_e p);
        case (p)
            PH_RED:   return PH_GREEN;
            PH_GREEN: return PH_BLUE;
            default:  return PH_RED;
        endcase
    endfunction
endpackage

// File: rtl/pal_entry_seq.sv
module pal_entry_seq
    import pal_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             idx_we,
    input  logic [IDX_W-1:0] idx_wdata,
    input  logic             data_we,
    input  logic [BUS_W-1:0] data_wdata,
    output logic             commit,
    output logic [IDX_W-1:0] commit_addr,
    output rgb_t             commit_rgb
);
    logic [IDX_W-1:0]  ptr_q;
    comp_phase_e       phase_q;
    logic [COMP_W-1:0] red_q, grn_q;
    logic [COMP_W-1:0] comp;
    logic              unused_hi_bits;

    assign comp           = data_wdata[COMP_W-1:0];
    assign unused_hi_bits = ^data_wdata[BUS_W-1:COMP_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q   <= '0;
            phase_q <= PH_RED;
            red_q   <= '0;
            grn_q   <= '0;
        end else if (idx_we) begin
            ptr_q   <= idx_wdata;
            phase_q <= PH_RED;
        end else if (data_we) begin
            phase_q <= next_phase(phase_q);
            case (phase_q)
                PH_RED:   red_q <= comp;
                PH_GREEN: grn_q <= comp;
                default:  ptr_q <= ptr_q + 1'b1;
            endcase
        end
    end

    assign commit      = data_we && !idx_we && (phase_q == PH_BLUE);
    assign commit_addr = ptr_q;
    assign commit_rgb  = '{r: red_q, g: grn_q, b: comp};

    assert_phase_red_after_index_R2: assert property (@(posedge clk) disable iff (rst)
        idx_we |=> phase_q == PH_RED);
    assert_ptr_load_R2: assert property (@(posedge clk) disable iff (rst)
        idx_we |=> ptr_q == $past(idx_wdata));
    assert_ptr_advance_R4: assert property (@(posedge clk) disable iff (rst)
        (data_we && !idx_we && phase_q == PH_BLUE) |=> ptr_q == $past(ptr_q) + 1'b1);
    assert_ptr_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (data_we && !idx_we && phase_q != PH_BLUE) |=> $stable(ptr_q));
    assert_no_commit_after_index_R8: assert property (@(posedge clk) disable iff (rst)
        idx_we |=> !commit);
endmodule

// File: rtl/pal_store.sv
module pal_store
    import pal_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             commit,
    input  logic [IDX_W-1:0] commit_addr,
    input  rgb_t             commit_rgb,
    input  logic             mask_we,
    input  logic [IDX_W-1:0] mask_wdata,
    input  logic [IDX_W-1:0] pix_idx,
    output rgb_t             rgb_q
);
    localparam int DEPTH = 1 << IDX_W;

    rgb_t             table_mem [DEPTH];
    logic [IDX_W-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (commit) table_mem[commit_addr] <= commit_rgb;
    end

    always_ff @(posedge clk) begin
        if (rst)          mask_q <= '1;
        else if (mask_we) mask_q <= mask_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) rgb_q <= '0;
        else     rgb_q <= table_mem[pix_idx & mask_q];
    end

    assert_mask_load_R7: assert property (@(posedge clk) disable iff (rst)
        mask_we |=> mask_q == $past(mask_wdata));
    assert_mask_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !mask_we |=> $stable(mask_q));
endmodule

// File: rtl/pal_dac_port.sv
module pal_dac_port
    import pal_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             idx_we,
    input  logic [IDX_W-1:0] idx_wdata,
    input  logic             data_we,
    input  logic [BUS_W-1:0] data_wdata,
    input  logic             mask_we,
    input  logic [IDX_W-1:0] mask_wdata,
    input  logic [IDX_W-1:0] pix_idx,
    output logic [RGB_W-1:0] rgb_out
);
    logic             commit;
    logic [IDX_W-1:0] commit_addr;
    rgb_t             commit_rgb;
    rgb_t             rgb_q;

    pal_entry_seq #(.IDX_W(IDX_W), .BUS_W(BUS_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .idx_we      (idx_we),
        .idx_wdata   (idx_wdata),
        .data_we     (data_we),
        .data_wdata  (data_wdata),
        .commit      (commit),
        .commit_addr (commit_addr),
        .commit_rgb  (commit_rgb)
    );

    pal_store #(.IDX_W(IDX_W)) u_store (
        .clk         (clk),
        .rst         (rst),
        .commit      (commit),
        .commit_addr (commit_addr),
        .commit_rgb  (commit_rgb),
        .mask_we     (mask_we),
        .mask_wdata  (mask_wdata),
        .pix_idx     (pix_idx),
        .rgb_q       (rgb_q)
    );

    assign rgb_out = rgb_q;

    assert_reset_output_R1: assert property (@(posedge clk)
        $past(rst) |-> rgb_out == '0);
endmodule

// File: tb/pal_dac_port_bench.sv
`timescale 1ns/1ps
module pal_dac_port_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        idx_we = 1'b0, data_we = 1'b0, mask_we = 1'b0;
    logic [7:0]  idx_wdata = '0, data_wdata = '0, mask_wdata = '0, pix_idx = '0;
    logic [17:0] rgb_out;
    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pal_dac_port u_pal_dac_port (
        .clk(clk), .rst(rst),
        .idx_we(idx_we), .idx_wdata(idx_wdata),
        .data_we(data_we), .data_wdata(data_wdata),
        .mask_we(mask_we), .mask_wdata(mask_wdata),
        .pix_idx(pix_idx), .rgb_out(rgb_out)
    );

    function automatic logic [17:0] pack(input logic [7:0] r, g, b);
        return {r[5:0], g[5:0], b[5:0]};
    endfunction

    task automatic check(input string req, input logic [17:0] act, exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%05h expected=%05h", req, act, exp);
        end
    endtask

    task automatic wr_idx(input logic [7:0] v);
        @(negedge clk); idx_we = 1'b1; idx_wdata = v;
        @(negedge clk); idx_we = 1'b0;
    endtask

    task automatic wr_data(input logic [7:0] v);
        @(negedge clk); data_we = 1'b1; data_wdata = v;
        @(negedge clk); data_we = 1'b0;
    endtask

    task automatic wr_mask(input logic [7:0] v);
        @(negedge clk); mask_we = 1'b1; mask_wdata = v;
        @(negedge clk); mask_we = 1'b0;
    endtask

    task automatic wr_entry(input logic [7:0] r, g, b);
        wr_data(r); wr_data(g); wr_data(b);
    endtask

    task automatic lookup(input logic [7:0] i, output logic [17:0] v);
        @(negedge clk); pix_idx = i;
        @(posedge clk); #1 v = rgb_out;
    endtask

    task automatic t_reset();
        logic [17:0] v;
        repeat (3) @(posedge clk);
        #1 check("R1 output in reset", rgb_out, 18'h0);
        @(negedge clk); rst = 1'b0;
        #1 check("R1 output after reset edge", rgb_out, 18'h0);
        wr_entry(8'h11, 8'h22, 8'h33);   // pointer must start at 0
        lookup(8'h00, v);
        check("R1 pointer at zero", v, pack(8'h11, 8'h22, 8'h33));
        wr_idx(8'h80); wr_entry(8'h05, 8'h06, 8'h07);
        lookup(8'h80, v);
        check("R1 mask starts at FF", v, pack(8'h05, 8'h06, 8'h07));
    endtask

    task automatic t_order_and_bits();
        logic [17:0] v;
        wr_idx(8'h20); wr_entry(8'h01, 8'h02, 8'h03);
        lookup(8'h20, v);
        check("R3 red green blue order", v, pack(8'h01, 8'h02, 8'h03));
        wr_idx(8'h21); wr_entry(8'hFF, 8'hC1, 8'h40);
        lookup(8'h21, v);
        check("R5 upper bits ignored", v, 18'h3F040);
    endtask

    task automatic t_wrap();
        logic [17:0] v;
        wr_idx(8'hFF);
        wr_entry(8'h3A, 8'h3B, 8'h3C);
        wr_entry(8'h0A, 8'h0B, 8'h0C);
        lookup(8'hFF, v);
        check("R4 entry 255", v, pack(8'h3A, 8'h3B, 8'h3C));
        lookup(8'h00, v);
        check("R4 wrap to entry 0", v, pack(8'h0A, 8'h0B, 8'h0C));
    endtask

    task automatic t_partial();
        logic [17:0] v;
        wr_idx(8'h05); wr_entry(8'h15, 8'h16, 8'h17);
        wr_idx(8'h05); wr_data(8'h2A); wr_data(8'h2B);
        lookup(8'h05, v);
        check("R9 partial write keeps entry", v, pack(8'h15, 8'h16, 8'h17));
        wr_idx(8'h06); wr_entry(8'h01, 8'h3E, 8'h1C);
        lookup(8'h06, v);
        check("R2 index restarts at red", v, pack(8'h01, 8'h3E, 8'h1C));
        lookup(8'h05, v);
        check("R2 staged bytes discarded", v, pack(8'h15, 8'h16, 8'h17));
    endtask

    task automatic t_mask();
        logic [17:0] v;
        wr_idx(8'h0F); wr_entry(8'h0F, 8'h0F, 8'h0F);
        wr_idx(8'hFF); wr_entry(8'h30, 8'h31, 8'h32);
        wr_mask(8'h0F);
        lookup(8'hFF, v);
        check("R7 mask applied to index", v, pack(8'h0F, 8'h0F, 8'h0F));
        wr_mask(8'hFF);
        lookup(8'hFF, v);
        check("R6 full index after mask FF", v, pack(8'h30, 8'h31, 8'h32));
        @(negedge clk); pix_idx = 8'h0F;
        #1 check("R6 output holds before edge", rgb_out, pack(8'h30, 8'h31, 8'h32));
        @(posedge clk); #1
        check("R6 output after one edge", rgb_out, pack(8'h0F, 8'h0F, 8'h0F));
    endtask

    task automatic t_priority();
        logic [17:0] v;
        wr_idx(8'h09); wr_entry(8'h09, 8'h09, 8'h09);
        wr_idx(8'h09); wr_data(8'h01); wr_data(8'h02);
        @(negedge clk);
        idx_we = 1'b1; idx_wdata = 8'h0A; data_we = 1'b1; data_wdata = 8'h3F;
        @(negedge clk); idx_we = 1'b0; data_we = 1'b0;
        wr_entry(8'h11, 8'h12, 8'h13);
        lookup(8'h0A, v);
        check("R8 index wins over data", v, pack(8'h11, 8'h12, 8'h13));
        lookup(8'h09, v);
        check("R8 simultaneous byte not committed", v, pack(8'h09, 8'h09, 8'h09));
    endtask

    task automatic t_stream();
        logic [17:0] v;
        int bad = 0;
        wr_idx(8'h40);
        for (int n = 0; n < 192; n++) wr_data(8'(n & 63));
        for (int e = 0; e < 64; e++) begin
            lookup(8'(8'h40 + e), v);
            if (v !== pack(8'((3*e) & 63), 8'((3*e+1) & 63), 8'((3*e+2) & 63))) bad++;
        end
        check("R10 64 streamed entries mismatches", 18'(bad), 18'h0);
    endtask

    initial begin
        t_reset();
        t_order_and_bits();
        t_wrap();
        t_partial();
        t_mask();
        t_priority();
        t_stream();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule